// File: doc/BRIEF.md
# ADC Pacer and Trigger Sequencer

This block issues the conversion strobes for an analog-to-digital converter and holds the converted result for a host. A host writes three small registers: a control register that holds the operating mode, a channel/gain register whose value drives the converter's input selection, and a divisor register that sets the strobe period. A pacer timer counts a prescaled time base, nominally 600 kHz taken from the system clock. Once started, it emits a one-cycle strobe every `divisor` time-base ticks.

The start event depends on the mode. In software-start mode, a write to the channel/gain register starts the pacer. In external-trigger mode, a falling edge on a trigger pin starts it, after a two-flop synchroniser. Any write to the control register stops the pacer, and so does a terminal-count pulse from a DMA engine. When the converter reports completion, the full 12-bit sample is captured at once and a done flag is raised. The host reads the low byte and then the high byte, and reading the high byte clears the flag.

Top module: `adc_pacer_seq`

## Requirements
- R1: After reset, `strobe_o` and `req_o` are low, and the control, channel/gain and divisor registers read 0.
- R2: The divisor register (address 2) keeps only bits 5:0, and bits 7:6 read back as 0. A divisor of 0 gives a period of 64 ticks.
- R3: Mode value 1 (control bits 1:0 at address 0) is software start. A write to the channel/gain register (address 1) starts an idle pacer, and that register's value appears on `chan_gain_o`. The first strobe comes `divisor*CLK_PER_TICK` cycles after the write edge, and later strobes come at that same period.
- R4: Any write to the control register stops the pacer in the same edge. No further strobe follows, and control bit 6 (running) reads 0.
- R5: A pulse on `dma_tc_i` stops a running pacer, and no further strobe follows.
- R6: Mode value 2 is external trigger. A falling edge on `ext_trig_i` starts the pacer, and the first strobe comes `divisor*CLK_PER_TICK + 2` cycles after the first clock edge that sees the low level. In this mode a channel/gain write does not start the pacer.
- R7: Start events that arrive while the pacer is running are ignored, and the strobe phase is unchanged.
- R8: A `conv_done_i` pulse latches `conv_data_i`. Address 3 returns bits 7:0, and address 4 returns bits 11:8 zero-extended. The same pulse sets the done flag (control bit 7) and `req_o`.
- R9: A read of address 4 clears the done flag and `req_o`. If a completion arrives in the same cycle, the flag stays set.
- R10: In mode values 0 and 3, neither a channel/gain write nor a trigger edge starts the pacer.
- R11: Each strobe is exactly one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write enable |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read enable (side effect on address 4) |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ext_trig_i | input | 1 | External start trigger, asynchronous, falling-edge active |
| conv_done_i | input | 1 | Converter completion pulse |
| conv_data_i | input | 12 | Converter sample |
| dma_tc_i | input | 1 | DMA terminal-count pulse |
| strobe_o | output | 1 | Conversion strobe, one cycle |
| req_o | output | 1 | Result-ready request for interrupt or DMA service |
| chan_gain_o | output | 8 | Channel/gain register value |

## Verification
A software start captures the write at one edge, and the strobe flop rises exactly `divisor*CLK_PER_TICK` edges later. A trigger start adds two edges for the synchroniser and the edge detector. The bench builds every latency check by counting falling clock edges from the negative edge at which the stimulus was released. That count is then compared with the figure computed from the divisor and the prescale value, so a single-cycle error in either direction is reported. The done flag, `req_o` and the result bytes are due one edge after `conv_done_i`, and they are sampled at the following falling edge. Checks that a strobe is absent watch `strobe_o` over a window longer than a full period.

// File: rtl/adc_pacer_pkg.sv
package adc_pacer_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_SW   = 2'd1,
    MODE_EXT  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CHG  = 3'd1;
  localparam logic [2:0] ADDR_DIV  = 3'd2;
  localparam logic [2:0] ADDR_RLO  = 3'd3;
  localparam logic [2:0] ADDR_RHI  = 3'd4;
endpackage

// File: rtl/adc_pacer_sync_edge.sv
module adc_pacer_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= async_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= sync_q[STAGES-1];
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];

  a_r6_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/adc_pacer_timer.sv
module adc_pacer_timer #(
  parameter int unsigned CLK_PER_TICK = 83,
  parameter int unsigned DIV_W        = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             running_o,
  output logic             strobe_o
);
  localparam int unsigned PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int unsigned CNT_W = DIV_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(CLK_PER_TICK - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'((1 << DIV_W) - 1);

  logic             run_q, strobe_q, tick;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q, period_last;

  // divisor 0 means the full 2^DIV_W ticks
  assign period_last = (div_i == '0) ? FULL_LAST
                                     : ({1'b0, div_i} - CNT_W'(1));
  assign tick = run_q && (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      strobe_q <= 1'b0;
      pre_q    <= '0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (start_i && !run_q) begin
        run_q <= 1'b1;
        pre_q <= '0;
        cnt_q <= '0;
      end else if (run_q) begin
        if (tick) begin
          pre_q <= '0;
          // >= tolerates a divisor lowered mid-period
          if (cnt_q >= period_last) begin
            cnt_q    <= '0;
            strobe_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

  assign running_o = run_q;
  assign strobe_o  = strobe_q;

  a_r4_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!run_q && !strobe_q));
  a_r3_strobe_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q |-> $past(run_q));
  a_r11_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && CLK_PER_TICK > 1) |=> !strobe_q);
  a_r7_no_rephase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !stop_i && !tick) |=> (pre_q == $past(pre_q) + PRE_W'(1)));
endmodule

// File: rtl/adc_pacer_regs.sv
module adc_pacer_regs
  import adc_pacer_pkg::*;
#(
  parameter int unsigned DIV_W = 6,
  parameter int unsigned RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_en_i,
  output logic [7:0]       rdata_o,
  input  logic             running_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  output mode_e            mode_o,
  output logic [7:0]       chg_o,
  output logic [DIV_W-1:0] div_o,
  output logic             done_o,
  output logic             ctrl_wr_o,
  output logic             chg_wr_o
);
  mode_e            mode_q;
  logic [7:0]       chg_q;
  logic [DIV_W-1:0] div_q;
  logic [RES_W-1:0] res_q;
  logic             done_q;
  logic [15:0]      res_ext;
  logic             hi_rd;

  assign ctrl_wr_o = wr_en_i && (addr_i == ADDR_CTRL);
  assign chg_wr_o  = wr_en_i && (addr_i == ADDR_CHG);
  assign hi_rd     = rd_en_i && (addr_i == ADDR_RHI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      chg_q  <= '0;
      div_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_CTRL: mode_q <= mode_e'(wdata_i[1:0]);
        ADDR_CHG:  chg_q  <= wdata_i;
        ADDR_DIV:  div_q  <= wdata_i[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  // whole sample captured at once so both bytes belong together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (conv_done_i) begin
        res_q  <= conv_data_i;
        done_q <= 1'b1;
      end else if (hi_rd) begin
        done_q <= 1'b0;
      end
    end
  end

  assign res_ext = 16'(res_q);

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = {done_q, running_i, 4'b0000, mode_q};
      ADDR_CHG:  rdata_o = chg_q;
      ADDR_DIV:  rdata_o = 8'(div_q);
      ADDR_RLO:  rdata_o = res_ext[7:0];
      ADDR_RHI:  rdata_o = res_ext[15:8];
      default:   rdata_o = 8'h00;
    endcase
  end

  assign mode_o = mode_q;
  assign chg_o  = chg_q;
  assign div_o  = div_q;
  assign done_o = done_q;

  a_r8_done_on_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> done_q);
  a_r9_hi_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd && !conv_done_i) |=> !done_q);
  a_r8_result_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(res_q));
endmodule

// File: rtl/adc_pacer_seq.sv
module adc_pacer_seq
  import adc_pacer_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK = 83,
  parameter int unsigned DIV_W        = 6,
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_en_i,
  output logic [7:0]       rdata_o,
  input  logic             ext_trig_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic             dma_tc_i,
  output logic             strobe_o,
  output logic             req_o,
  output logic [7:0]       chan_gain_o
);
  mode_e            mode;
  logic [DIV_W-1:0] div;
  logic             done, ctrl_wr, chg_wr, trig_fall, running;
  logic             start, stop;

  adc_pacer_regs #(.DIV_W(DIV_W), .RES_W(RES_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i, .rd_en_i, .rdata_o,
    .running_i   (running),
    .conv_done_i, .conv_data_i,
    .mode_o      (mode),
    .chg_o       (chan_gain_o),
    .div_o       (div),
    .done_o      (done),
    .ctrl_wr_o   (ctrl_wr),
    .chg_wr_o    (chg_wr)
  );

  adc_pacer_sync_edge #(.STAGES(SYNC_STAGES)) u_trig (
    .clk_i, .rst_ni,
    .async_i (ext_trig_i),
    .fall_o  (trig_fall)
  );

  assign start = ((mode == MODE_SW)  && chg_wr) ||
                 ((mode == MODE_EXT) && trig_fall);
  assign stop  = ctrl_wr || dma_tc_i;

  adc_pacer_timer #(.CLK_PER_TICK(CLK_PER_TICK), .DIV_W(DIV_W)) u_timer (
    .clk_i, .rst_ni,
    .div_i     (div),
    .start_i   (start),
    .stop_i    (stop),
    .running_o (running),
    .strobe_o  (strobe_o)
  );

  assign req_o = done;

  a_r10_idle_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode == MODE_IDLE || mode == MODE_RSVD) && !running) |=> !running);
  a_r5_tc_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_tc_i |=> !running);
endmodule

// File: tb/adc_pacer_seq_tb.sv
module adc_pacer_seq_tb;
  localparam int unsigned P = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ext_trig_i = 1'b1;
  logic        conv_done_i = 1'b0;
  logic [11:0] conv_data_i = '0;
  logic        dma_tc_i = 1'b0;
  logic        strobe_o, req_o;
  logic [7:0]  chan_gain_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  adc_pacer_seq #(.CLK_PER_TICK(P)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  // falling edges from now until strobe_o is seen high; -1 if none
  task automatic measure(int limit, output int lat);
    lat = -1;
    for (int i = 0; i <= limit; i++) begin
      if (strobe_o) begin lat = i; break; end
      @(negedge clk_i);
    end
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (strobe_o) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 strobe", strobe_o, 0);
    chk("R1 req", req_o, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 chg", d, 0);
    rd(3'd2, d); chk("R1 div", d, 0);
  endtask

  task automatic t_div_mask;
    logic [7:0] d;
    wr(3'd2, 8'hFF);
    rd(3'd2, d); chk("R2 div mask", d, 8'h3F);
  endtask

  task automatic t_sw_mode;
    int lat;
    wr(3'd0, 8'h01);
    wr(3'd2, 8'd5);
    wr(3'd1, 8'h37);
    chk("R3 chan_gain_o", chan_gain_o, 8'h37);
    measure(400, lat); chk("R3 first strobe", lat, 5*P);
    @(negedge clk_i); chk("R11 width", strobe_o, 0);
    measure(400, lat); chk("R3 period", lat + 1, 5*P);
    @(negedge clk_i);
    measure(400, lat); chk("R3 period again", lat + 1, 5*P);
  endtask

  task automatic t_ctrl_stop;
    logic [7:0] d;
    repeat (4) @(negedge clk_i);
    wr(3'd0, 8'h01);
    quiet(200, "R4 no strobe after ctrl write");
    rd(3'd0, d); chk("R4 running bit", d[6], 0);
  endtask

  task automatic t_tc_stop;
    int lat;
    wr(3'd1, 8'h11);
    measure(400, lat); chk("R5 restart", lat, 5*P);
    repeat (3) @(negedge clk_i);
    dma_tc_i = 1'b1;
    @(negedge clk_i);
    dma_tc_i = 1'b0;
    quiet(200, "R5 no strobe after tc");
  endtask

  task automatic t_ext_mode;
    int lat;
    wr(3'd0, 8'h02);
    wr(3'd2, 8'd4);
    wr(3'd1, 8'h5A);
    quiet(100, "R6 chg write does not start");
    ext_trig_i = 1'b0;
    @(negedge clk_i);
    measure(400, lat); chk("R6 trigger latency", lat, 4*P + 2);
    // second falling edge while running
    @(negedge clk_i); ext_trig_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); ext_trig_i = 1'b0;
    measure(400, lat); chk("R7 phase kept", lat + 3, 4*P);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_div_zero;
    int lat;
    wr(3'd0, 8'h01);
    wr(3'd2, 8'd0);
    wr(3'd1, 8'h01);
    measure(1000, lat); chk("R2 divisor 0 is 64", lat, 64*P);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_idle_modes;
    for (int m = 0; m < 4; m += 3) begin
      wr(3'd0, 8'(m));
      wr(3'd2, 8'd2);
      ext_trig_i = 1'b1;
      repeat (4) @(negedge clk_i);
      wr(3'd1, 8'h22);
      ext_trig_i = 1'b0;
      quiet(100, (m == 0) ? "R10 mode 0 no start" : "R10 mode 3 no start");
    end
  endtask

  task automatic t_result;
    logic [7:0] d;
    @(negedge clk_i);
    conv_data_i = 12'hABC; conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk("R8 req", req_o, 1);
    rd(3'd0, d); chk("R8 done bit", d[7], 1);
    rd(3'd3, d); chk("R8 low byte", d, 8'hBC);
    rd(3'd4, d); chk("R8 high byte", d, 8'h0A);
    chk("R9 req cleared", req_o, 0);
    rd(3'd0, d); chk("R9 done cleared", d[7], 0);
    // completion coincides with high-byte read
    @(negedge clk_i);
    conv_data_i = 12'h123; conv_done_i = 1'b1;
    addr_i = 3'd4; rd_en_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0; rd_en_i = 1'b0;
    chk("R9 set wins", req_o, 1);
    rd(3'd3, d); chk("R8 new low byte", d, 8'h23);
    rd(3'd4, d); chk("R8 new high byte", d, 8'h01);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_div_mask();
    t_sw_mode();
    t_ctrl_stop();
    t_tc_stop();
    t_ext_mode();
    t_div_zero();
    t_idle_modes();
    t_result();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule